// File: doc/BRIEF.md
# Bridge Parity Error Response Controller

This block watches both sides of a two-sided bus bridge for parity faults and decides how the bridge reacts to them. On each side it forms even parity over the 32 address/data lines and the 4 command/byte-enable lines. It then compares that result with the parity bit that arrives one clock later. The block does not move data itself. It sits beside the bridge's transaction logic and drives the claim, ready and error signals that depend on parity.

Secondary side: an address parity fault can stop the bridge from claiming the transaction, so the transaction ends in a master abort. The same fault can raise a system error toward the primary side. Primary side: a data parity fault on a Type 0 configuration write to the bridge's own registers is reported on the data parity error line. The write itself still completes. The block also holds three sticky status bits. Software clears each of them by writing a one.

Forwarded read data keeps its incoming parity bit unchanged. The initiator on the far side does the checking, so reads do not pass through this block's comparators.

Top module: `brg_parity_ctl`

## Requirements
- R1: Expected parity for a phase is the XOR of all 32 AD bits and all 4 C/BE bits (even parity). The parity input sampled one clock after that phase is compared with it. A match raises no error on any output.
- R2: If a secondary address phase has a parity fault and `bctl_perr_en` is 1, `s_devsel_n` stays high in the clock after that address phase, even when `s_hit` was 1.
- R3: If there is no fault, or `bctl_perr_en` is 0, `s_devsel_n` goes low in the clock after a secondary address phase whose `s_hit` was 1. It stays high when `s_hit` was 0.
- R4: Any secondary address parity fault sets `st_s_dpe` two clocks after the address phase, whatever the enables are.
- R5: `p_serr_n` is low for exactly one clock, two clocks after a faulty secondary address phase, only when `cmd_serr_en` and `bctl_perr_en` are both 1. `st_p_sse` is set in that same clock.
- R6: `p_trdy_n` is low in every clock where `p_data_vld` and `p_cfg_wr` are both 1, whether or not that phase's parity turns out good.
- R7: With `cmd_perr_en` 1, `p_perr_n` is low two clocks after each faulty configuration-write data phase, for one clock per faulty phase. Back-to-back faulty phases keep it low without a gap.
- R8: With `cmd_perr_en` 0, `p_perr_n` stays high on a faulty configuration-write data phase.
- R9: A faulty configuration-write data phase sets `st_p_dpe` two clocks after the phase, whatever `cmd_perr_en` is.
- R10: `st_clr` clears status bits at the next edge: bit 0 clears `st_p_dpe`, bit 1 clears `st_p_sse`, bit 2 clears `st_s_dpe`. A set event on the same edge wins over the clear.
- R11: While `rst_n` is low, every active-low output is high and all status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_perr_en | input | 1 | Command register parity response enable |
| cmd_serr_en | input | 1 | Command register system error enable |
| bctl_perr_en | input | 1 | Bridge control parity response enable |
| p_ad | input | 32 | Primary address/data |
| p_cbe | input | 4 | Primary command/byte enables |
| p_par | input | 1 | Primary parity, one clock behind its phase |
| p_data_vld | input | 1 | Primary data phase completes this clock |
| p_cfg_wr | input | 1 | Current phase is a Type 0 configuration write to the bridge |
| p_trdy_n | output | 1 | Target ready for the configuration write; register file commits on it |
| p_perr_n | output | 1 | Primary data parity error |
| p_serr_n | output | 1 | Primary system error pulse |
| s_ad | input | 32 | Secondary address/data |
| s_cbe | input | 4 | Secondary command/byte enables |
| s_par | input | 1 | Secondary parity, one clock behind its phase |
| s_addr_vld | input | 1 | Secondary address phase this clock |
| s_hit | input | 1 | Address decodes to or through the bridge |
| s_devsel_n | output | 1 | Secondary device select (claim) |
| st_clr | input | 3 | Write-one-to-clear strobes for the status bits |
| st_p_dpe | output | 1 | Primary detected parity error status |
| st_p_sse | output | 1 | Signaled system error status |
| st_s_dpe | output | 1 | Secondary detected parity error status |

## Verification
The bench aims at the four combinations of the two system error enables on a faulty secondary address. A design that gated the error with the wrong enable would pulse `p_serr_n` or set `st_p_sse` in a combination where both must stay quiet. It checks claiming with and without the bridge control enable. A design that always suppressed or always granted the claim would show the wrong `s_devsel_n` in one of the two cases.

Back-to-back faulty configuration-write phases test the per-phase holding of `p_perr_n`. A design that stretched or merged pulses would mismatch in the following clock. A clear strobe is issued on the same edge as a fresh error, and a design that let the clear win would drop a status bit that must stay set.

// File: rtl/brg_parity_ctl.sv
module brg_parity_ctl #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_perr_en,
  input  logic             cmd_serr_en,
  input  logic             bctl_perr_en,
  input  logic [AD_W-1:0]  p_ad,
  input  logic [CBE_W-1:0] p_cbe,
  input  logic             p_par,
  input  logic             p_data_vld,
  input  logic             p_cfg_wr,
  output logic             p_trdy_n,
  output logic             p_perr_n,
  output logic             p_serr_n,
  input  logic [AD_W-1:0]  s_ad,
  input  logic [CBE_W-1:0] s_cbe,
  input  logic             s_par,
  input  logic             s_addr_vld,
  input  logic             s_hit,
  output logic             s_devsel_n,
  input  logic [2:0]       st_clr,
  output logic             st_p_dpe,
  output logic             st_p_sse,
  output logic             st_s_dpe
);

  logic s_a_q, s_hit_q, s_exp_q;
  logic p_d_q, p_exp_q;
  logic perr_q, serr_q;
  logic s_ape, p_dpe_ev, serr_ev;

  // phase pipeline: parity arrives one clock after its phase (R1)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_a_q   <= 1'b0;
      s_hit_q <= 1'b0;
      s_exp_q <= 1'b0;
      p_d_q   <= 1'b0;
      p_exp_q <= 1'b0;
    end else begin
      s_a_q   <= s_addr_vld;
      s_hit_q <= s_addr_vld & s_hit;
      s_exp_q <= ^{s_ad, s_cbe};
      p_d_q   <= p_data_vld & p_cfg_wr;
      p_exp_q <= ^{p_ad, p_cbe};
    end
  end

  assign s_ape    = s_a_q & (s_par ^ s_exp_q);
  assign p_dpe_ev = p_d_q & (p_par ^ p_exp_q);
  assign serr_ev  = s_ape & cmd_serr_en & bctl_perr_en;

  assign s_devsel_n = ~(s_hit_q & ~(s_ape & bctl_perr_en));
  assign p_trdy_n   = ~(p_data_vld & p_cfg_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_q   <= 1'b0;
      serr_q   <= 1'b0;
      st_p_dpe <= 1'b0;
      st_p_sse <= 1'b0;
      st_s_dpe <= 1'b0;
    end else begin
      perr_q   <= p_dpe_ev & cmd_perr_en;
      serr_q   <= serr_ev;
      st_p_dpe <= (st_p_dpe & ~st_clr[0]) | p_dpe_ev;
      st_p_sse <= (st_p_sse & ~st_clr[1]) | serr_ev;
      st_s_dpe <= (st_s_dpe & ~st_clr[2]) | s_ape;
    end
  end

  assign p_perr_n = ~perr_q;
  assign p_serr_n = ~serr_q;

  AST_CLAIM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ape && bctl_perr_en) |-> s_devsel_n); // R2
  AST_SDPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    s_ape |=> st_s_dpe); // R4
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !p_serr_n |-> $past(cmd_serr_en && bctl_perr_en)); // R5
  AST_SERR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !p_serr_n |-> st_p_sse); // R5
  AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !p_perr_n |-> ($past(cmd_perr_en) && st_p_dpe)); // R7 R8
  AST_PDPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    p_dpe_ev |=> st_p_dpe); // R9

endmodule

// File: tb/sim_brg_parity_ctl.sv
module sim_brg_parity_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_perr_en = 0, cmd_serr_en = 0, bctl_perr_en = 0;
  logic [31:0] p_ad = 0, s_ad = 0;
  logic [3:0]  p_cbe = 0, s_cbe = 0;
  logic p_par = 0, p_data_vld = 0, p_cfg_wr = 0;
  logic s_par = 0, s_addr_vld = 0, s_hit = 0;
  logic [2:0] st_clr = 0;
  logic p_trdy_n, p_perr_n, p_serr_n, s_devsel_n, st_p_dpe, st_p_sse, st_s_dpe;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brg_parity_ctl u0 (.*);

  // reference model state
  int m_sa, m_shit, m_sexp, m_pd, m_pexp, m_perr, m_serr, m_pdpe, m_psse, m_sdpe;

  function automatic int evpar(input logic [31:0] ad, input logic [3:0] cbe);
    return $countones({ad, cbe}) % 2;
  endfunction

  always @(posedge clk) begin
    int s_err, p_err;
    if (!rst_n) begin
      m_sa = 0; m_shit = 0; m_sexp = 0; m_pd = 0; m_pexp = 0;
      m_perr = 0; m_serr = 0; m_pdpe = 0; m_psse = 0; m_sdpe = 0;
    end else begin
      s_err = (m_sa != 0) && (int'(s_par) != m_sexp);
      p_err = (m_pd != 0) && (int'(p_par) != m_pexp);
      m_perr = (p_err != 0) && cmd_perr_en;
      m_serr = (s_err != 0) && cmd_serr_en && bctl_perr_en;
      if (st_clr[0]) m_pdpe = 0;
      if (st_clr[1]) m_psse = 0;
      if (st_clr[2]) m_sdpe = 0;
      if (p_err != 0) m_pdpe = 1;
      if (m_serr != 0) m_psse = 1;
      if (s_err != 0) m_sdpe = 1;
      m_sa = s_addr_vld; m_shit = s_addr_vld && s_hit;
      m_sexp = evpar(s_ad, s_cbe);
      m_pd = p_data_vld && p_cfg_wr;
      m_pexp = evpar(p_ad, p_cbe);
    end
  end

  task automatic cmp(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    int s_err;
    #1;
    s_err = (m_sa != 0) && (int'(s_par) != m_sexp);
    cmp("R2/R3 s_devsel_n", s_devsel_n, !((m_shit != 0) && !((s_err != 0) && bctl_perr_en)));
    cmp("R6 p_trdy_n", p_trdy_n, !(p_data_vld && p_cfg_wr));
    cmp("R7/R8 p_perr_n", p_perr_n, m_perr == 0);
    cmp("R5 p_serr_n", p_serr_n, m_serr == 0);
    cmp("R9/R10 st_p_dpe", st_p_dpe, m_pdpe != 0);
    cmp("R5/R10 st_p_sse", st_p_sse, m_psse != 0);
    cmp("R4/R10 st_s_dpe", st_s_dpe, m_sdpe != 0);
    @(negedge clk);
    st_clr = 3'b000;
  endtask

  // R1: parity driven one clock after its phase; bad flips it
  task automatic sec_addr(input logic hit, input logic bad);
    logic [31:0] ad = $urandom;
    logic [3:0] cbe = 4'($urandom);
    s_addr_vld = 1; s_hit = hit; s_ad = ad; s_cbe = cbe;
    step();
    s_addr_vld = 0; s_hit = 0; s_ad = $urandom;
    s_par = logic'(evpar(ad, cbe)) ^ bad;
    step();
    step(); step();
  endtask

  task automatic cfg_wr(input int n, input logic [7:0] badmask);
    logic prev_par = 0, prev_bad = 0;
    for (int i = 0; i <= n; i++) begin
      logic [31:0] ad = $urandom;
      logic [3:0] cbe = 4'($urandom);
      if (i > 0) p_par = prev_par ^ prev_bad;
      if (i < n) begin
        p_data_vld = 1; p_cfg_wr = 1; p_ad = ad; p_cbe = cbe;
        prev_par = logic'(evpar(ad, cbe)); prev_bad = badmask[i];
      end else begin
        p_data_vld = 0; p_cfg_wr = 0;
      end
      step();
    end
    step(); step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); step(); step();    // R11 reset state
    rst_n = 1; step();
    // R1 R3 clean parity, hit and miss
    bctl_perr_en = 1; cmd_serr_en = 1;
    sec_addr(1, 0); sec_addr(0, 0);
    // R2 suppressed claim, R4 R5 serr with both enables
    sec_addr(1, 1);
    st_clr = 3'b110; step();
    // R3 claim when bctl clear; R5 no serr
    bctl_perr_en = 0; sec_addr(1, 1);
    cmd_serr_en = 0; bctl_perr_en = 1; sec_addr(1, 1);
    cmd_serr_en = 0; bctl_perr_en = 0; sec_addr(0, 1);
    st_clr = 3'b111; step();
    // R6 R7 back-to-back faulty phases
    cmd_perr_en = 1; cfg_wr(4, 8'b0110);
    cfg_wr(3, 8'b0000);
    // R8 R9 perr disabled, status still set
    st_clr = 3'b001; step();
    cmd_perr_en = 0; cfg_wr(2, 8'b0011);
    // R10 set wins over clear on the same edge
    cmd_serr_en = 1; bctl_perr_en = 1; cmd_perr_en = 1;
    s_addr_vld = 1; s_hit = 1; s_ad = 32'h0000_0001; s_cbe = 0;
    step();
    s_addr_vld = 0; s_hit = 0; s_par = 0; st_clr = 3'b110;
    step(); step();
    st_clr = 3'b111; step(); step();
    // mixed traffic on both sides
    for (int k = 0; k < 40; k++) begin
      cmd_perr_en = 1'($urandom); cmd_serr_en = 1'($urandom); bctl_perr_en = 1'($urandom);
      if (k % 2 == 0) sec_addr(1'($urandom), 1'($urandom));
      else cfg_wr(1 + k % 3, 8'($urandom));
      st_clr = 3'($urandom); step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule